// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block collects interrupt requests from on-chip sources and presents them to a processor on four active-high interrupt pins. It exposes two 32-bit registers on a simple memory-mapped host bus: a pending-request register, whose bits the hardware sources set, and an enable register, which gates each pending bit before it reaches a pin.

The host acknowledges interrupts by writing the request register. The stored value becomes the bitwise AND of the old contents and the written data. A 0 in the written word clears that bit, and a 1 leaves it alone. This lets the software clear one source without a read-modify-write race against new arrivals.

Pending bits are routed onto the pins by fixed groups, and one pin is shared by several sources. Bit 0 feeds pin 0. Bit 2 feeds pin 1. Bits 2 to 8 are ORed onto pin 2. Bit 10 feeds pin 3. The pins are registered outputs.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While reset is held and after it is released, both registers read zero and all four pins are low.
- R2: Byte offset 0x0 reads the request register and offset 0x4 reads the enable register. Every other offset reads zero. Reads never change any state.
- R3: A host write to offset 0x0 makes the request register equal to its previous value ANDed with the write data, one clock later.
- R4: A high bit on the hardware request input sets the same bit of the request register at the next clock. Bits with no pin mapping are stored and read back too.
- R5: When a hardware request and an acknowledging write hit the same bit in the same cycle, the bit ends up set.
- R6: A host write to offset 0x4 replaces the enable register with the write data.
- R7: A pin is high only if at least one of its mapped bits is both pending and enabled. The pin follows the register state with one clock of delay and stays high while such a bit remains.
- R8: Pin 0 reflects request bit 0 and pin 3 reflects request bit 10.
- R9: Pin 2 is the OR of request bits 2 through 8. Pin 1 reflects request bit 2 alone.
- R10: A bus cycle without select, or a write to an offset other than 0x0 and 0x4, leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus cycle targets this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the block's window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |
| hw_req | input | 32 | Per-bit request-set strobes from the sources |
| irq_pin | output | 4 | Registered interrupt pins, active high |

## Verification
A corrupted pending or enable bit becomes visible in two places. It shows on the read data at once for the selected offset. It shows on the pins one clock later, provided the bit belongs to a pin group. A bit outside every group can only be seen through a readback, so the bench reads both registers often. Each pin is compared against a reference model on every clock. A lost set during an acknowledge, or a wrong group mask, therefore shows up as a pin mismatch within one cycle.

// File: rtl/irq_pkg.sv
// Shared constants for the masked interrupt controller.
// Assumes a 32-bit data path and four CPU interrupt pins.
package irq_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_PINS = 4;
    localparam int ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] OFS_REQ = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ENA = 4'h4;

    // Request bits that feed a given pin; pin 2 is the shared group.
    function automatic logic [DATA_W-1:0] pin_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        case (idx)
            0: m[0] = 1'b1;
            1: m[2] = 1'b1;
            2: m[8:2] = '1;
            3: m[10] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/irq_decode.sv
// Bus decode: turns a select/write/offset triple into register strobes
// and a read mux select. Assumes the offset is a byte address; any
// offset other than the two register offsets is unused.
module irq_decode
    import irq_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_req,
    output logic              wr_ena,
    output logic              hit_req,
    output logic              hit_ena
);
    // Offset match and write strobe generation.
    always_comb begin
        hit_req = (bus_addr == OFS_REQ);
        hit_ena = (bus_addr == OFS_ENA);
        wr_req  = bus_sel && bus_wr && hit_req;
        wr_ena  = bus_sel && bus_wr && hit_ena;
    end
endmodule

// File: rtl/irq_regs.sv
// Request and enable registers. The request register takes an AND with
// host write data, then ORs in hardware sets, so a set always wins over
// an acknowledge in the same cycle. The enable register is plain R/W.
module irq_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_ena,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_req,
    output logic [DATA_W-1:0] req_q,
    output logic [DATA_W-1:0] ena_q
);
    logic [DATA_W-1:0] req_kept;
    logic [DATA_W-1:0] req_next;

    // Next request value: acknowledge by AND, then merge new sets.
    always_comb begin
        req_kept = wr_req ? (req_q & wdata) : req_q;
        req_next = req_kept | hw_req;
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            ena_q <= '0;
        end else begin
            req_q <= req_next;
            if (wr_ena) ena_q <= wdata;
        end
    end
endmodule

// File: rtl/irq_pin_map.sv
// Routes enabled, pending bits onto the CPU pins through per-pin masks
// from the package, one registered OR per pin.
module irq_pin_map
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   req_q,
    input  logic [DATA_W-1:0]   ena_q,
    output logic [NUM_PINS-1:0] pin_q
);
    logic [DATA_W-1:0] live;

    // Bits that are both pending and enabled.
    always_comb live = req_q & ena_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [DATA_W-1:0] MASK = pin_mask(p);
        // Registered OR over this pin's group.
        always_ff @(posedge clk) begin
            if (!rst_n) pin_q[p] <= 1'b0;
            else        pin_q[p] <= |(live & MASK);
        end
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Top of the masked interrupt controller: bus decode, the two registers,
// the pin router and a side-effect-free read mux.
module irq_mask_ctrl
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [DATA_W-1:0]   hw_req,
    output logic [NUM_PINS-1:0] irq_pin
);
    logic wr_req, wr_ena, hit_req, hit_ena;
    logic [DATA_W-1:0] req_q, ena_q;

    irq_decode u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .wr_req  (wr_req),
        .wr_ena  (wr_ena),
        .hit_req (hit_req),
        .hit_ena (hit_ena)
    );

    irq_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_req(wr_req),
        .wr_ena(wr_ena),
        .wdata (bus_wdata),
        .hw_req(hw_req),
        .req_q (req_q),
        .ena_q (ena_q)
    );

    irq_pin_map u_pins (
        .clk  (clk),
        .rst_n(rst_n),
        .req_q(req_q),
        .ena_q(ena_q),
        .pin_q(irq_pin)
    );

    // Read mux; unmapped offsets return zero.
    always_comb begin
        if (hit_req)      bus_rdata = req_q;
        else if (hit_ena) bus_rdata = ena_q;
        else              bus_rdata = '0;
    end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Assertion checker for irq_mask_ctrl, attached by bind. Observes ports
// and the two register outputs.
module irq_mask_ctrl_chk
    import irq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   hw_req,
    input logic [NUM_PINS-1:0] irq_pin,
    input logic [DATA_W-1:0]   req_q,
    input logic [DATA_W-1:0]   ena_q
);
    logic ack_wr, ena_wr;
    assign ack_wr = bus_sel && bus_wr && (bus_addr == OFS_REQ);
    assign ena_wr = bus_sel && bus_wr && (bus_addr == OFS_ENA);

    AST_RESET_PINS_LOW: assert property (@(posedge clk) !rst_n |=> (irq_pin == '0 && req_q == '0)); // R1
    AST_ACK_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && hw_req == '0) |=> req_q == ($past(req_q) & $past(bus_wdata))); // R3
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req != '0) |=> ((req_q & $past(hw_req)) == $past(hw_req))); // R5
    AST_ENA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ena_wr |=> ena_q == $past(bus_wdata)); // R6
    AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_wr |=> $stable(ena_q)); // R10
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |=> irq_pin == '0); // R7
    AST_PIN_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_pin[0] == $past(req_q[0] & ena_q[0]) &&
                   irq_pin[3] == $past(req_q[10] & ena_q[10]))); // R8
    AST_PIN_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_pin[2] == $past(|(req_q[8:2] & ena_q[8:2])) &&
                   irq_pin[1] == $past(req_q[2] & ena_q[2]))); // R9
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .hw_req   (hw_req),
    .irq_pin  (irq_pin),
    .req_q    (req_q),
    .ena_q    (ena_q)
);

// File: tb/irq_mask_ctrl_test.sv
// Bench for irq_mask_ctrl: behavioural reference model updated on each
// rising edge, outputs compared on each falling edge.
module irq_mask_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, hw_req = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_pin;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] m_req = '0, m_ena = '0;
    logic [3:0]  m_pin = '0;

    always #10 clk = ~clk;

    irq_mask_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_req(hw_req), .irq_pin(irq_pin)
    );

    function automatic logic [3:0] pins_of(input logic [31:0] r, input logic [31:0] e);
        logic [3:0] p;
        logic [31:0] v;
        v = r & e;
        p[0] = v[0];
        p[1] = v[2];
        p[2] = 1'b0;
        for (int b = 2; b <= 8; b++) if (v[b]) p[2] = 1'b1;
        p[3] = v[10];
        return p;
    endfunction

    function automatic logic [31:0] read_of(input logic [3:0] a);
        if (a == 4'h0) return m_req;
        if (a == 4'h4) return m_ena;
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, advance the model at the edge, compare after.
    task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                       input logic [31:0] d, input logic [31:0] h);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; hw_req = h;
        @(posedge clk);
        if (!rst_n) begin
            m_req = '0; m_ena = '0; m_pin = '0;
        end else begin
            m_pin = pins_of(m_req, m_ena);
            if (s && w && a == 4'h0) m_req = m_req & d;
            m_req = m_req | h;
            if (s && w && a == 4'h4) m_ena = d;
        end
        @(negedge clk);
        chk("R7 R8 R9 pins", {28'h0, irq_pin}, {28'h0, m_pin});
        chk("R2 read mux", bus_rdata, read_of(a));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 32'h0, 32'h0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(1'b0, 1'b0, 4'h0, 32'h0, 32'hFFFF_FFFF);
        cyc(1'b0, 1'b0, 4'h0, 32'h0, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 4'h0, 32'h0, 32'h0);
        chk("R1 request after reset", bus_rdata, 32'h0);
        cyc(1'b1, 1'b0, 4'h4, 32'h0, 32'h0);
        chk("R1 enable after reset", bus_rdata, 32'h0);
        chk("R1 pins after reset", {28'h0, irq_pin}, 32'h0);

        // R6: enable write and readback
        cyc(1'b1, 1'b1, 4'h4, 32'hFFFF_FFFF, 32'h0);
        cyc(1'b1, 1'b0, 4'h4, 32'h0, 32'h0);
        chk("R6 enable load", bus_rdata, 32'hFFFF_FFFF);

        // R4: hardware set, including an unmapped bit 31
        cyc(1'b0, 1'b0, 4'h0, 32'h0, 32'h8000_0001);
        cyc(1'b1, 1'b0, 4'h0, 32'h0, 32'h0);
        chk("R4 set stored", bus_rdata, 32'h8000_0001);
        chk("R8 pin0 up", {31'h0, irq_pin[0]}, 32'h1);

        // R3: acknowledge bit 0 only
        cyc(1'b1, 1'b1, 4'h0, 32'hFFFF_FFFE, 32'h0);
        cyc(1'b1, 1'b0, 4'h0, 32'h0, 32'h0);
        chk("R3 ack by AND", bus_rdata, 32'h8000_0000);
        chk("R8 pin0 down", {28'h0, irq_pin}, 32'h0);

        // R9: bit 5 drives shared pin only; bit 2 drives pins 1 and 2
        cyc(1'b0, 1'b0, 4'h0, 32'h0, 32'h0000_0020);
        idle(1);
        chk("R9 bit5 on shared pin", {28'h0, irq_pin}, 32'h4);
        cyc(1'b1, 1'b1, 4'h0, 32'h0, 32'h0000_0004);
        idle(1);
        chk("R9 bit2 on two pins", {28'h0, irq_pin}, 32'h6);

        // R5: set and ack of same bit together
        cyc(1'b1, 1'b1, 4'h0, 32'h0, 32'h0000_0400);
        cyc(1'b1, 1'b0, 4'h0, 32'h0, 32'h0);
        chk("R5 set beats ack", bus_rdata, 32'h0000_0400);
        chk("R8 pin3 up", {28'h0, irq_pin}, 32'h8);

        // R7: masking drops the pin one clock later, pending bit kept
        cyc(1'b1, 1'b1, 4'h4, 32'hFFFF_FBFF, 32'h0);
        idle(1);
        chk("R7 masked pin low", {28'h0, irq_pin}, 32'h0);

        // R10: unselected write and unmapped-offset write are ignored
        cyc(1'b0, 1'b1, 4'h0, 32'h0, 32'h0);
        cyc(1'b1, 1'b1, 4'h8, 32'h0, 32'h0);
        cyc(1'b1, 1'b0, 4'h0, 32'h0, 32'h0);
        chk("R10 request kept", bus_rdata, 32'h0000_0400);
        cyc(1'b1, 1'b0, 4'h4, 32'h0, 32'h0);
        chk("R10 enable kept", bus_rdata, 32'hFFFF_FBFF);
        cyc(1'b1, 1'b0, 4'hC, 32'h0, 32'h0);
        chk("R2 unmapped reads zero", bus_rdata, 32'h0);

        // Mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [3:0] a;
            a = {$urandom_range(0, 3), 2'b00};
            if (($urandom & 7) == 0) a = 4'($urandom);
            cyc(1'($urandom), 1'($urandom), a, $urandom | $urandom,
                $urandom & $urandom & $urandom & $urandom);
        end

        // Reset mid-run restores zero state
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 4'h0, 32'h0, 32'h0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b0, 4'h4, 32'h0, 32'h0);
        chk("R1 enable after second reset", bus_rdata, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule